// File: doc/BRIEF.md
# Packed Single-Precision Compare and Min/Max Unit

This block compares two packed operands, each 64 bits wide and holding two independent single-precision lanes. The low lane is bits 31:0 and the high lane is bits 63:32. A float has a sign bit (bit 31 of the lane), an 8-bit exponent biased by 127 (bits 30:23) and a 23-bit fraction (bits 22:0). An 8-bit opcode selects the operation:

- Three opcodes produce a per-lane truth mask: greater-or-equal, greater-than and equal.
- Two opcodes return the smaller or the larger operand of each lane.

The result is registered, so it appears on the cycle after a request is accepted.

Any encoding whose exponent field is zero counts as zero, whatever its sign and fraction bits hold. Ordering is found by a sign-magnitude integer compare on the exponent and fraction bits. The unit raises no flags and no exceptions, and it gives no special ordering to infinities or NaNs.

A two-state machine tracks whether the output holds a fresh result:
- **ST_IDLE**: no fresh result is shown.
- **ST_SHOW**: a result is shown with `out_valid` high.

The transitions are:
- **T_ACCEPT** moves ST_IDLE to ST_SHOW.
- **T_AGAIN** keeps ST_SHOW when another request is accepted.
- **T_DRAIN** moves ST_SHOW to ST_IDLE when no request is accepted.
- **T_WAIT** keeps ST_IDLE when no request is accepted.

A request is accepted when `in_valid` is high and the opcode is supported.

Top module: `pkcmp_unit`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it rises with no request, `out_valid` is 0 and `out_data` is all zero.
- R2: An accepted request gives `out_valid`=1 on the next cycle. A cycle with `in_valid`=0, or with an unsupported opcode, gives `out_valid`=0 on the next cycle, and `out_data` keeps its previous value.
- R3: Opcode 8'h90 writes 32'hFFFFFFFF to each lane where A >= B, and 32'h00000000 where it is not.
- R4: Opcode 8'hA0 writes 32'hFFFFFFFF to each lane where A > B, and 32'h00000000 otherwise.
- R5: Opcode 8'hB0 writes 32'hFFFFFFFF to each lane where A equals B, and 32'h00000000 otherwise.
- R6: Opcode 8'h94 returns the smaller operand of each lane, and opcode 8'hA4 returns the larger. The returned value has the operand's original bits.
- R7: An operand with exponent bits 30:23 equal to zero is treated as zero. Two such operands compare equal whatever their sign and fraction bits.
- R8: When min or max sees two operands that are equal by R7 ordering, it returns operand B's lane.
- R9: Lanes are independent: the result in bits 31:0 depends only on bits 31:0 of A and B, and likewise for bits 63:32.
- R10: Negative values order below positive values. Among negative values, a larger magnitude is smaller.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op_code | input | 8 | Operation select |
| src_a | input | 64 | Packed operand A |
| src_b | input | 64 | Packed operand B |
| out_valid | output | 1 | Fresh result present |
| out_data | output | 64 | Registered packed result |

## Verification
The hardest case to reach is one where two operands have different bit patterns yet are equal under the ordering rules. The tie-to-B rule and the zero-exponent rule can only be seen at the ports in that case. The stimulus table therefore pairs values that differ only in sign, or only in the fraction of a zero-exponent encoding. Operand A in those pairs carries a pattern that differs from B, so the returned bits show which operand was picked. The stimulus also mixes lanes whose outcomes disagree within one request, which exposes any crossing between lanes.

// File: rtl/pkcmp_pkg.sv
package pkcmp_pkg;
    localparam logic [7:0] OPC_GE  = 8'h90;
    localparam logic [7:0] OPC_GT  = 8'hA0;
    localparam logic [7:0] OPC_EQ  = 8'hB0;
    localparam logic [7:0] OPC_MIN = 8'h94;
    localparam logic [7:0] OPC_MAX = 8'hA4;

    typedef enum logic [2:0] {
        K_NONE,
        K_GE,
        K_GT,
        K_EQ,
        K_MIN,
        K_MAX
    } kind_t;

    typedef enum logic {
        ST_IDLE,
        ST_SHOW
    } state_t;
endpackage

// File: rtl/pkcmp_decode.sv
module pkcmp_decode
    import pkcmp_pkg::*;
(
    input  logic [7:0] op_i,
    output kind_t      kind_o,
    output logic       ok_o,
    output logic       is_mask_o
);
    always_comb begin
        unique case (op_i)
            OPC_GE:  kind_o = K_GE;
            OPC_GT:  kind_o = K_GT;
            OPC_EQ:  kind_o = K_EQ;
            OPC_MIN: kind_o = K_MIN;
            OPC_MAX: kind_o = K_MAX;
            default: kind_o = K_NONE;
        endcase
    end

    assign ok_o      = (kind_o != K_NONE);
    assign is_mask_o = (kind_o == K_GE) || (kind_o == K_GT) || (kind_o == K_EQ);
endmodule

// File: rtl/pkcmp_lane.sv
module pkcmp_lane
    import pkcmp_pkg::*;
#(
    parameter int W  = 32,
    parameter int EW = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  kind_t        kind_i,
    output logic [W-1:0] res_o
);
    localparam int MW = W - 1;

    logic          a_zero, b_zero;
    logic          a_neg, b_neg;
    logic [MW-1:0] a_mag, b_mag;
    logic          a_gt, a_eq, a_lt;

    // Zero-exponent encodings collapse onto a single +0 key (R7)
    assign a_zero = (a_i[W-2 -: EW] == '0);
    assign b_zero = (b_i[W-2 -: EW] == '0);
    assign a_mag  = a_zero ? '0 : a_i[MW-1:0];
    assign b_mag  = b_zero ? '0 : b_i[MW-1:0];
    assign a_neg  = !a_zero && a_i[W-1];
    assign b_neg  = !b_zero && b_i[W-1];

    assign a_eq = (a_neg == b_neg) && (a_mag == b_mag);

    always_comb begin
        if (a_neg != b_neg)
            a_gt = !a_neg;
        else if (!a_neg)
            a_gt = (a_mag > b_mag);
        else
            a_gt = (a_mag < b_mag);
    end

    assign a_lt = !a_gt && !a_eq;

    always_comb begin
        unique case (kind_i)
            K_GE:    res_o = {W{a_gt | a_eq}};
            K_GT:    res_o = {W{a_gt}};
            K_EQ:    res_o = {W{a_eq}};
            K_MIN:   res_o = a_lt ? a_i : b_i;   // tie -> B (R8)
            K_MAX:   res_o = a_gt ? a_i : b_i;   // tie -> B (R8)
            default: res_o = '0;
        endcase
    end

    always_comb begin
        AST_GT_EQ_EXCL: assert ($isunknown({a_gt, a_eq}) || !(a_gt && a_eq)); // R4
    end
endmodule

// File: rtl/pkcmp_unit.sv
module pkcmp_unit
    import pkcmp_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int LANE_W = 32,
    parameter int EXP_W  = 8,
    parameter int OP_W   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [OP_W-1:0]         op_code,
    input  logic [LANES*LANE_W-1:0] src_a,
    input  logic [LANES*LANE_W-1:0] src_b,
    output logic                    out_valid,
    output logic [LANES*LANE_W-1:0] out_data
);
    localparam int DW = LANES * LANE_W;

    kind_t          kind;
    logic           op_ok, op_mask;
    logic           accept;
    logic [DW-1:0]  lane_res;
    logic           mask_q;
    state_t         state, state_nx;

    pkcmp_decode u_dec (
        .op_i      (op_code[7:0]),
        .kind_o    (kind),
        .ok_o      (op_ok),
        .is_mask_o (op_mask)
    );

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            pkcmp_lane #(.W(LANE_W), .EW(EXP_W)) u_lane (
                .a_i    (src_a[g*LANE_W +: LANE_W]),
                .b_i    (src_b[g*LANE_W +: LANE_W]),
                .kind_i (kind),
                .res_o  (lane_res[g*LANE_W +: LANE_W])
            );

            AST_MASK_FORM: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && mask_q) |->
                ((out_data[g*LANE_W +: LANE_W] == '0) ||
                 (out_data[g*LANE_W +: LANE_W] == '1))); // R3
        end
    endgenerate

    assign accept = in_valid && op_ok;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions: T_ACCEPT, T_AGAIN, T_DRAIN, T_WAIT
    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = accept ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_nx = accept ? ST_SHOW : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
            mask_q   <= 1'b0;
        end else if (accept) begin
            out_data <= lane_res;
            mask_q   <= op_mask;
        end
    end

    assign out_valid = (state == ST_SHOW);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_ok) |=> out_valid); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && op_ok) |=> (!out_valid && $stable(out_data))); // R2
    AST_BAD_OP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_ok) |=> !out_valid); // R2
endmodule

// File: tb/pkcmp_unit_test.sv
module pkcmp_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  op_code = 8'h00;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        out_valid;
    logic [63:0] out_data;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    pkcmp_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .out_data(out_data)
    );

    // {opcode, A, B, expected}
    localparam int NV = 13;
    localparam logic [199:0] VEC [NV] = '{
        {8'h90, 64'h40000000_3F800000, 64'h3F800000_3F800000, 64'hFFFFFFFF_FFFFFFFF}, // R3
        {8'h90, 64'hC0000000_3F000000, 64'hBF800000_3F800000, 64'h00000000_00000000}, // R3 R10
        {8'hA0, 64'h40000000_3F800000, 64'h3F800000_3F800000, 64'hFFFFFFFF_00000000}, // R4
        {8'hA0, 64'hBF800000_3F800000, 64'hC0000000_BF800000, 64'hFFFFFFFF_FFFFFFFF}, // R4 R10
        {8'hB0, 64'h00000000_3F800000, 64'h80000000_3F800001, 64'hFFFFFFFF_00000000}, // R5 R7
        {8'hB0, 64'h00000001_80400000, 64'h00000000_00000000, 64'hFFFFFFFF_FFFFFFFF}, // R7
        {8'hA0, 64'h00000001_3F800000, 64'h80000000_00700000, 64'h00000000_FFFFFFFF}, // R7
        {8'h94, 64'h40000000_BF800000, 64'h3F800000_3F000000, 64'h3F800000_BF800000}, // R6
        {8'hA4, 64'h40000000_BF800000, 64'h3F800000_3F000000, 64'h40000000_3F000000}, // R6
        {8'h94, 64'h80000000_00000005, 64'h00000000_80000000, 64'h00000000_80000000}, // R8
        {8'hA4, 64'h80000000_00000005, 64'h00000000_80000000, 64'h00000000_80000000}, // R8
        {8'hA4, 64'hC0000000_BF800000, 64'hBF800000_C0000000, 64'hBF800000_BF800000}, // R10
        {8'h90, 64'h3F800000_40000000, 64'h40000000_3F800000, 64'h00000000_FFFFFFFF}  // R9
    };

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic issue(input logic v, input logic [7:0] op, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        in_valid = v;
        op_code  = op;
        src_a    = a;
        src_b    = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin : watchdog
        #200000;
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [63:0] held;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", {63'd0, out_valid}, 64'd0);
        check("R1 data in reset", out_data, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", {63'd0, out_valid}, 64'd0);
        check("R1 data after reset", out_data, 64'd0);

        for (int i = 0; i < NV; i++) begin
            issue(1'b1, VEC[i][199:192], VEC[i][191:128], VEC[i][127:64]);
            check($sformatf("R2 valid vec %0d", i), {63'd0, out_valid}, 64'd1);
            check($sformatf("R3-table vec %0d", i), out_data, VEC[i][63:0]);
        end

        // R2: unsupported opcode leaves data and drops valid
        held = out_data;
        issue(1'b1, 8'h9E, 64'h40000000_40000000, 64'h3F800000_3F800000);
        check("R2 bad opcode valid", {63'd0, out_valid}, 64'd0);
        check("R2 bad opcode hold", out_data, held);

        // R2: in_valid low with a good opcode leaves data
        issue(1'b0, 8'h90, 64'h40000000_40000000, 64'h3F800000_3F800000);
        check("R2 idle valid", {63'd0, out_valid}, 64'd0);
        check("R2 idle hold", out_data, held);

        // R9: high lane true, low lane false under equality
        issue(1'b1, 8'hB0, 64'h3F800000_3F800000, 64'h3F800000_40000000);
        check("R9 eq lane split", out_data, 64'hFFFFFFFF_00000000);

        // R5: sign differs on nonzero values
        issue(1'b1, 8'hB0, 64'hBF800000_3F800000, 64'h3F800000_3F800000);
        check("R5 sign differs", out_data, 64'h00000000_FFFFFFFF);

        // R6 back-to-back requests
        @(negedge clk);
        in_valid = 1'b1; op_code = 8'hA4;
        src_a = 64'hC0000000_3F800000; src_b = 64'h3F000000_40000000;
        @(negedge clk);
        check("R6 b2b max", out_data, 64'h3F000000_40000000);
        op_code = 8'h94;
        @(negedge clk);
        in_valid = 1'b0;
        check("R6 b2b min", out_data, 64'hC0000000_3F800000);
        check("R2 b2b valid", {63'd0, out_valid}, 64'd1);

        // R1: reset mid-run clears the output
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset valid", {63'd0, out_valid}, 64'd0);
        check("R1 mid reset data", out_data, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule